// File: doc/BRIEF.md
# Fault-Latching Protection Controller

This block guards a deflection stage. It watches four fault inputs: low supply, supply dip, X-ray detector and a grounded PLL filter node. Each fault input is synchronized and then held according to its own release rule. While any fault is present, the block holds every output control in a safe state. The horizontal drive, the supply (B+) drive, the unlock indicator and the vertical outputs have their output enables removed, so they float. Blanking is forced on and a discharge strobe is driven for the PLL capacitor.

A register-valid flag records whether the register interface has reloaded the settings since the last latched fault. The block tells the register interface through `reload_req_o` that a reload is needed. A write to the control register sets the flag. Once every fault has been released and the flag is set, the outputs come back one group at a time, with a fixed spacing of `STEP_LEN` clocks between groups.

Top module: `prot_ctrl`

## Requirements
- R1: During and directly after synchronous reset, all four output enables are 0, `blank_o` and `pll_discharge_o` are 1, `reload_req_o` is 1 and `fault_status_o` is 0.
- R2: Each fault input passes through `SYNC_STAGES` flip-flops. A fault held for at least `SYNC_STAGES`+2 clocks shows in `fault_status_o` at bit 0 for low supply, bit 1 for supply dip, bit 2 for X-ray and bit 3 for the grounded PLL node.
- R3: While any status bit is set, all four output enables are 0 and `blank_o` and `pll_discharge_o` are 1. This state is reached at most two clocks after the status bit sets.
- R4: While a synchronized low-supply, dip or X-ray input is active, the register-valid flag is cleared and `reload_req_o` is 1. The flag is set, and `reload_req_o` drops, only by a `ctrl_wr_i` pulse given while none of those inputs is active.
- R5: The low-supply and X-ray status bits stay set after their inputs go inactive. Each clears only on a `soft_start_i` pulse given while `reload_req_o` is 0. A `soft_start_i` pulse given while `reload_req_o` is 1 has no effect.
- R6: The dip status bit clears without any soft start once its input is inactive and `reload_req_o` is 0.
- R7: The PLL-node status bit follows its synchronized input without latching. Releasing the node needs no reload.
- R8: Recovery from the safe state happens in this order, with each step exactly `STEP_LEN` clocks after the one before: discharge off; then horizontal drive and unlock indicator enabled together; then vertical outputs; then B+ drive; then blanking released.
- R9: A fault arriving part-way through recovery returns every output to the safe state of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| low_supply_i | input | 1 | Low-supply fault flag, asynchronous |
| supply_dip_i | input | 1 | Supply-dip fault flag, asynchronous |
| xray_i | input | 1 | X-ray detector fault, asynchronous |
| pll_gnd_i | input | 1 | PLL filter node held to ground, asynchronous |
| ctrl_wr_i | input | 1 | One-clock pulse: the control register was written |
| soft_start_i | input | 1 | One-clock pulse: soft start command from the serial bus |
| hdrv_en_o | output | 1 | Horizontal drive output enable |
| bdrv_en_o | output | 1 | B+ drive output enable |
| unlock_en_o | output | 1 | Unlock indicator output enable |
| vout_en_o | output | 1 | Vertical outputs enable |
| blank_o | output | 1 | Blanking, 1 = blanked |
| pll_discharge_o | output | 1 | PLL capacitor discharge strobe |
| reload_req_o | output | 1 | Registers must be reloaded |
| fault_status_o | output | 4 | Per-fault status, bit positions as in R2 |

## Verification
The bench builds the block with `SYNC_STAGES` = 2 and `STEP_LEN` = 4. With these values a whole recovery fits in about twenty clocks. That makes it practical to sweep all fifteen non-zero combinations of the four fault inputs and to run every release path on its own. The short step lets the bench measure the exact spacing of each recovery step. It also lets the bench inject a fault part-way through recovery.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int F_LOW  = 0;
  localparam int F_DIP  = 1;
  localparam int F_XRAY = 2;
  localparam int F_PLL  = 3;
  localparam int N_LATCHED = 3;
  localparam int N_FAULT   = 4;

  localparam logic [2:0] ST_SAFE   = 3'd0;
  localparam logic [2:0] ST_DISOFF = 3'd1;
  localparam logic [2:0] ST_HORIZ  = 3'd2;
  localparam logic [2:0] ST_VERT   = 3'd3;
  localparam logic [2:0] ST_SUPPLY = 3'd4;
  localparam logic [2:0] ST_RUN    = 3'd5;
endpackage

// File: rtl/prot_sync.sv
module prot_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/prot_latch.sv
module prot_latch
  import prot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_LATCHED-1:0] fault_s,
  input  logic                 ctrl_wr_i,
  input  logic                 soft_start_i,
  output logic [N_LATCHED-1:0] latched,
  output logic                 reg_valid
);
  always_ff @(posedge clk) begin
    if (rst)            reg_valid <= 1'b0;
    else if (|fault_s)  reg_valid <= 1'b0;
    else if (ctrl_wr_i) reg_valid <= 1'b1;
  end

  for (genvar i = 0; i < N_LATCHED; i++) begin : g_fault
    logic release_ok;
    if (i == F_DIP) begin : g_supply_release
      assign release_ok = reg_valid;
    end else begin : g_bus_release
      assign release_ok = reg_valid & soft_start_i;
    end
    always_ff @(posedge clk) begin
      if (rst) latched[i] <= 1'b0;
      else     latched[i] <= fault_s[i] | (latched[i] & ~release_ok);
    end
  end

  p_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (|fault_s) |=> !reg_valid);
  p_noreload_r4: assert property (@(posedge clk) disable iff (rst)
    (latched[F_LOW] && !reg_valid) |=> latched[F_LOW]);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (latched[F_XRAY] && !soft_start_i) |=> latched[F_XRAY]);
  p_dip_release_r6: assert property (@(posedge clk) disable iff (rst)
    (latched[F_DIP] && !fault_s[F_DIP] && reg_valid) |=> !latched[F_DIP]);
endmodule

// File: rtl/prot_seq.sv
module prot_seq
  import prot_pkg::*;
#(
  parameter int STEP_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic any_fault,
  input  logic reg_valid,
  output logic hdrv_en_o,
  output logic bdrv_en_o,
  output logic unlock_en_o,
  output logic vout_en_o,
  output logic blank_o,
  output logic pll_discharge_o
);
  localparam int CW = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_LEN - 1);

  logic [2:0]    stage_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || any_fault) begin
      stage_q <= ST_SAFE;
      cnt_q   <= '0;
    end else if (stage_q == ST_SAFE && !reg_valid) begin
      cnt_q   <= '0;
    end else if (stage_q != ST_RUN) begin
      if (cnt_q == CNT_LAST) begin
        stage_q <= stage_q + 3'd1;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdrv_en_o       <= 1'b0;
      bdrv_en_o       <= 1'b0;
      unlock_en_o     <= 1'b0;
      vout_en_o       <= 1'b0;
      blank_o         <= 1'b1;
      pll_discharge_o <= 1'b1;
    end else begin
      pll_discharge_o <= (stage_q == ST_SAFE);
      hdrv_en_o       <= (stage_q >= ST_HORIZ);
      unlock_en_o     <= (stage_q >= ST_HORIZ);
      vout_en_o       <= (stage_q >= ST_VERT);
      bdrv_en_o       <= (stage_q >= ST_SUPPLY);
      blank_o         <= (stage_q < ST_RUN);
    end
  end

  p_enter_safe_r9: assert property (@(posedge clk) disable iff (rst)
    any_fault |=> (stage_q == ST_SAFE));
  p_safe_outputs_r3: assert property (@(posedge clk) disable iff (rst)
    (stage_q == ST_SAFE) |=> (blank_o && pll_discharge_o && !hdrv_en_o &&
                              !bdrv_en_o && !vout_en_o && !unlock_en_o));
  p_single_step_r8: assert property (@(posedge clk) disable iff (rst)
    (stage_q != ST_SAFE && !any_fault) |=> ((stage_q - $past(stage_q)) <= 3'd1));
  p_bdrv_after_vout_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bdrv_en_o) |-> $past(vout_en_o));
endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl
  import prot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STEP_LEN    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       low_supply_i,
  input  logic       supply_dip_i,
  input  logic       xray_i,
  input  logic       pll_gnd_i,
  input  logic       ctrl_wr_i,
  input  logic       soft_start_i,
  output logic       hdrv_en_o,
  output logic       bdrv_en_o,
  output logic       unlock_en_o,
  output logic       vout_en_o,
  output logic       blank_o,
  output logic       pll_discharge_o,
  output logic       reload_req_o,
  output logic [3:0] fault_status_o
);
  logic [N_FAULT-1:0]   raw, sync_q;
  logic [N_LATCHED-1:0] latched;
  logic                 reg_valid, any_fault;

  assign raw = {pll_gnd_i, xray_i, supply_dip_i, low_supply_i};

  prot_sync #(.W(N_FAULT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(sync_q));

  prot_latch u_latch (
    .clk(clk), .rst(rst), .fault_s(sync_q[N_LATCHED-1:0]),
    .ctrl_wr_i(ctrl_wr_i), .soft_start_i(soft_start_i),
    .latched(latched), .reg_valid(reg_valid));

  assign any_fault = (|latched) | sync_q[F_PLL];

  prot_seq #(.STEP_LEN(STEP_LEN)) u_seq (
    .clk(clk), .rst(rst), .any_fault(any_fault), .reg_valid(reg_valid),
    .hdrv_en_o(hdrv_en_o), .bdrv_en_o(bdrv_en_o), .unlock_en_o(unlock_en_o),
    .vout_en_o(vout_en_o), .blank_o(blank_o), .pll_discharge_o(pll_discharge_o));

  assign reload_req_o   = ~reg_valid;
  assign fault_status_o = {sync_q[F_PLL], latched};

  p_pll_follows_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(pll_gnd_i, 2) |-> !fault_status_o[F_PLL]);
endmodule

// File: tb/sim_prot_ctrl.sv
`timescale 1ns/1ps
module sim_prot_ctrl;
  localparam int STEP = 4;

  logic clk = 0, rst = 1;
  logic low_i = 0, dip_i = 0, xr_i = 0, pll_i = 0, wr_i = 0, ss_i = 0;
  logic hdrv, bdrv, unl, vout, blank, dis, rreq;
  logic [3:0] status;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prot_ctrl #(.SYNC_STAGES(2), .STEP_LEN(STEP)) u0 (
    .clk(clk), .rst(rst), .low_supply_i(low_i), .supply_dip_i(dip_i),
    .xray_i(xr_i), .pll_gnd_i(pll_i), .ctrl_wr_i(wr_i), .soft_start_i(ss_i),
    .hdrv_en_o(hdrv), .bdrv_en_o(bdrv), .unlock_en_o(unl), .vout_en_o(vout),
    .blank_o(blank), .pll_discharge_o(dis), .reload_req_o(rreq),
    .fault_status_o(status));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr();
    wr_i = 1; cyc(1); wr_i = 0;
  endtask

  task automatic pulse_ss();
    ss_i = 1; cyc(1); ss_i = 0;
  endtask

  function automatic int outs();
    return {hdrv, bdrv, unl, vout, blank, dis};
  endfunction

  task automatic chk_safe(input string req);
    chk(req, outs(), 6'b000011);
  endtask

  task automatic set_faults(input logic [3:0] v);
    {pll_i, xr_i, dip_i, low_i} = v;
  endtask

  // R8: recovery order and spacing, measured from the current cycle
  task automatic run_seq(input string tag);
    int t_dis = -1, t_hd = -1, t_v = -1, t_b = -1, t_bl = -1;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (t_dis < 0 && !dis)  t_dis = i;
      if (t_hd  < 0 && hdrv)  t_hd  = i;
      if (t_v   < 0 && vout)  t_v   = i;
      if (t_b   < 0 && bdrv)  t_b   = i;
      if (t_bl  < 0 && !blank) t_bl = i;
    end
    chk({"R8 horiz after discharge ", tag}, t_hd - t_dis, STEP);
    chk({"R8 vert after horiz ", tag},      t_v - t_hd,   STEP);
    chk({"R8 bdrv after vert ", tag},       t_b - t_v,    STEP);
    chk({"R8 blank after bdrv ", tag},      t_bl - t_b,   STEP);
    chk({"R8 final run state ", tag},       outs(), 6'b111100);
    chk({"R8 discharge seen ", tag},        (t_dis >= 0) ? 1 : 0, 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk_safe("R1 outputs in reset");
    chk("R1 reload_req in reset", rreq, 1);
    chk("R1 status in reset", status, 0);
    rst = 0;
    cyc(1);
    chk_safe("R1 outputs after reset");
    chk("R1 status after reset", status, 0);
    cyc(20);
    chk_safe("R4 stays safe without reload");
    chk("R4 reload_req before write", rreq, 1);
    pulse_wr();
    chk("R4 reload_req after write", rreq, 0);
    run_seq("startup");

    // low supply, then X-ray: bus soft start required after reload
    for (int f = 0; f < 3; f += 2) begin
      string nm = (f == 0) ? "low" : "xray";
      set_faults(4'(1 << f));
      cyc(8);
      chk({"R2 status set ", nm}, status, 1 << f);
      chk_safe({"R3 safe outputs ", nm});
      chk({"R4 reload_req during ", nm}, rreq, 1);
      pulse_wr();
      chk({"R4 write ignored while active ", nm}, rreq, 1);
      set_faults(4'b0);
      cyc(6);
      chk({"R5 stays latched ", nm}, status, 1 << f);
      pulse_ss();
      cyc(2);
      chk({"R5 soft start without reload ignored ", nm}, status, 1 << f);
      pulse_wr();
      chk({"R4 reload_req cleared ", nm}, rreq, 0);
      cyc(10);
      chk({"R5 no release before soft start ", nm}, status, 1 << f);
      chk_safe({"R5 still safe ", nm});
      pulse_ss();
      chk({"R5 released by soft start ", nm}, status, 0);
      run_seq(nm);
    end

    // supply dip: released by supply recovery after reload
    set_faults(4'b0010);
    cyc(8);
    chk("R2 status set dip", status, 2);
    chk_safe("R3 safe outputs dip");
    set_faults(4'b0);
    cyc(6);
    chk("R6 dip held until reload", status, 2);
    pulse_wr();
    cyc(2);
    chk("R6 dip released without soft start", status, 0);
    run_seq("dip");

    // PLL node: follows input, no reload
    set_faults(4'b1000);
    cyc(8);
    chk("R7 pll status while grounded", status, 8);
    chk_safe("R3 safe outputs pll");
    set_faults(4'b0);
    cyc(3);
    chk("R7 pll status after release", status, 0);
    chk("R7 no reload needed", rreq, 0);
    run_seq("pll");

    // R9: fault mid-recovery
    set_faults(4'b1000);
    cyc(8);
    set_faults(4'b0);
    for (int i = 0; i < 40 && !hdrv; i++) cyc(1);
    chk("R9 recovery reached horiz", hdrv, 1);
    set_faults(4'b1000);
    cyc(5);
    chk_safe("R9 back to safe mid-recovery");
    set_faults(4'b0);
    run_seq("after R9");

    // sweep of every fault combination
    for (int c = 1; c < 16; c++) begin
      set_faults(4'(c));
      cyc(8);
      chk($sformatf("R2 combo %0d status", c), status, c);
      chk_safe($sformatf("R3 combo %0d safe", c));
      set_faults(4'b0);
      cyc(6);
      chk($sformatf("R5 combo %0d latched part", c), status, c & 7);
      pulse_wr();
      cyc(2);
      pulse_ss();
      cyc(2);
      chk($sformatf("R5 combo %0d released", c), status, 0);
      chk($sformatf("R4 combo %0d reload done", c), rreq, (c & 7) ? 0 : 0);
    end
    run_seq("after sweep");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule